// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block is the column counter that sits behind the read and write path of a synchronous DRAM. A start strobe captures a starting column together with the burst mode: a burst-length code and an ordering select. From the next clock onward the block produces one column address per rising edge, one for each data beat. It raises a valid flag while a burst runs and a last flag on the final beat. The start column fixes an aligned block whose size is the burst length. Beats stay inside that block and wrap within it. They follow either a linear count or an XOR (interleaved) pattern.

A full-page burst walks the whole 256-column row linearly, without end, until a terminate input stops it. An interleaved full-page request is not a legal mode. The block flags it and runs an 8-beat interleaved burst in its place. A control state machine has two states. `ST_IDLE` means no burst is running. `ST_BURST` means a beat is presented in the current cycle. It has four transitions:
- `ST_IDLE -> ST_BURST` on start.
- `ST_BURST -> ST_BURST` on a restart strobe, or while beats remain.
- `ST_BURST -> ST_IDLE` on terminate.
- `ST_BURST -> ST_IDLE` after the last beat of a fixed-length burst.

Top module: `bst_col_seq`

## Requirements
- R1: While reset is held and after it is released, with no start, `col_vld`, `col_last` and `mode_err` are 0 and `col_addr` reads 0. `col_addr` reads 0 whenever `col_vld` is 0.
- R2: After a clock edge with `start` high, `col_vld` is 1 and `col_addr` equals the `start_col` sampled at that edge. This is beat 0.
- R3: In linear ordering (`wrap_il`=0), beat n has the low log2(BL) bits equal to (start + n) modulo BL. The upper column bits stay equal to those of the start column.
- R4: In interleaved ordering (`wrap_il`=1), beat n equals the start column with its low log2(BL) bits XORed with n. The upper bits are unchanged.
- R5: `bl_code` bits [1:0] select a burst length of 1, 2, 4 or 8 for codes 0 to 3 when bit 2 is 0. A fixed burst presents exactly BL beats, and `col_vld` is 0 in the cycle after the last beat.
- R6: `col_last` is 1 on the final beat of a fixed-length burst and on no other beat. It is never 1 in a full-page burst.
- R7: `bl_code` bit 2 set with linear ordering selects full page: the column increments modulo 256 every cycle with no end.
- R8: A clock edge with `term` high and `start` low during a burst ends it, so `col_vld` is 0 in the next cycle.
- R9: `bl_code` bit 2 set together with `wrap_il`=1 is illegal. `mode_err` is 1 on every beat of that burst, and the burst runs as an 8-beat interleaved burst.
- R10: A `start` during a burst aborts it. The next cycle shows beat 0 of the new burst at the new column and in the new mode, and `start` takes priority over `term`.
- R11: `bl_code` and `wrap_il` are sampled only on start. Changing them during a burst does not alter its columns or length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin (or restart) a burst at `start_col` |
| start_col | input | COL_W | First column of the burst |
| bl_code | input | 3 | Burst length code: 0..3 = 1,2,4,8 beats; bit 2 = full page |
| wrap_il | input | 1 | 0 = linear ordering, 1 = interleaved ordering |
| term | input | 1 | Stop the running burst |
| col_addr | output | COL_W | Column address of the current beat |
| col_vld | output | 1 | A beat is presented this cycle |
| col_last | output | 1 | Current beat is the last of a fixed burst |
| mode_err | output | 1 | Current burst was requested with an illegal mode |

## Verification
Several rules hold on every cycle and are checked continuously:
- A start always shows its column on the next cycle.
- `term` and the last beat always drop the valid flag.
- `col_last` and `mode_err` appear only on a valid beat.
- Columns outside the burst's aligned block never change between beats.
- A full-page burst always steps by one.

The exact beat order cannot be seen from a single-cycle property. This covers linear versus XOR ordering, the beat count for each length code, and the wrap point for every start offset. The directed scenarios compare these against a reference model. The same holds for the fallback of the illegal mode to 8 interleaved beats and for mode changes in mid-burst being ignored.

// File: rtl/bst_pkg.sv
package bst_pkg;

    // control state of the sequencer
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bst_state_e;

    // burst-length code field positions
    localparam int BLC_W      = 3;
    localparam int BLC_FULL_B = 2;

    // mode captured at each start strobe
    typedef struct packed {
        logic full;   // endless linear walk across the row
        logic il;     // XOR ordering
        logic err;    // illegal request, running as 8 interleaved beats
    } bst_mode_t;

endpackage

// File: rtl/bst_mode_dec.sv
module bst_mode_dec
    import bst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [BLC_W-1:0] bl_code,
    input  logic             wrap_il,
    output logic [COL_W-1:0] mask,
    output bst_mode_t        mode
);

    localparam logic [COL_W-1:0] MASK_ALL = {COL_W{1'b1}};
    localparam logic [COL_W-1:0] MASK_B8  = COL_W'(7);

    logic full_req;
    logic [COL_W-1:0] fixed_mask;

    assign full_req = bl_code[BLC_FULL_B];

    // fixed lengths: 2^code beats, mask = length - 1
    always_comb begin
        unique case (bl_code[1:0])
            2'd0: fixed_mask = '0;
            2'd1: fixed_mask = COL_W'(1);
            2'd2: fixed_mask = COL_W'(3);
            default: fixed_mask = COL_W'(7);
        endcase
    end

    always_comb begin
        mode.full = full_req & ~wrap_il;
        mode.il   = wrap_il;
        mode.err  = full_req & wrap_il;
        if (mode.full) begin
            mask = MASK_ALL;
        end else if (mode.err) begin
            mask = MASK_B8;
        end else begin
            mask = fixed_mask;
        end
    end

endmodule

// File: rtl/bst_beat_ctr.sv
module bst_beat_ctr #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [COL_W-1:0] beat
);

    logic [COL_W-1:0] beat_q;

    // counts beats since the last start; wraps at 2^COL_W for full page
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (clr) begin
            beat_q <= '0;
        end else if (adv) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    assign beat = beat_q;

endmodule

// File: rtl/bst_addr_gen.sv
module bst_addr_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             il,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] lin_sum;

    assign lin_sum = base + beat;

    // per bit: outside the burst block keep the base bit,
    // inside it take either the XOR or the linear sum bit
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        always_comb begin
            if (!mask[i]) begin
                col[i] = base[i];
            end else if (il) begin
                col[i] = base[i] ^ beat[i];
            end else begin
                col[i] = lin_sum[i];
            end
        end
    end

endmodule

// File: rtl/bst_col_seq.sv
module bst_col_seq
    import bst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       bl_code,
    input  logic             wrap_il,
    input  logic             term,
    output logic [COL_W-1:0] col_addr,
    output logic             col_vld,
    output logic             col_last,
    output logic             mode_err
);

    bst_state_e       state_q, state_d;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             full_q;
    logic             il_q;
    logic             err_q;

    logic [COL_W-1:0] dec_mask;
    bst_mode_t        dec_mode;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] gen_col;
    logic             in_burst;
    logic             final_beat;

    bst_mode_dec #(.COL_W(COL_W)) u_dec (
        .bl_code (bl_code),
        .wrap_il (wrap_il),
        .mask    (dec_mask),
        .mode    (dec_mode)
    );

    bst_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .adv   (in_burst),
        .beat  (beat)
    );

    bst_addr_gen #(.COL_W(COL_W)) u_gen (
        .base (base_q),
        .beat (beat),
        .mask (mask_q),
        .il   (il_q),
        .col  (gen_col)
    );

    assign in_burst   = (state_q == ST_BURST);
    assign final_beat = in_burst && !full_q && (beat == mask_q);

    // mode and start column captured only on a start strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            full_q <= 1'b0;
            il_q   <= 1'b0;
            err_q  <= 1'b0;
        end else if (start) begin
            base_q <= start_col;
            mask_q <= dec_mask;
            full_q <= dec_mode.full;
            il_q   <= dec_mode.il;
            err_q  <= dec_mode.err;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: start wins over term and over the last beat
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_BURST;
                end
            end
            ST_BURST: begin
                if (start) begin
                    state_d = ST_BURST;
                end else if (term || final_beat) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        col_vld  = 1'b0;
        col_last = 1'b0;
        mode_err = 1'b0;
        col_addr = '0;
        unique case (state_q)
            ST_IDLE: begin
                col_addr = '0;
            end
            ST_BURST: begin
                col_vld  = 1'b1;
                col_last = final_beat;
                mode_err = err_q;
                col_addr = gen_col;
            end
            default: begin
                col_addr = '0;
            end
        endcase
    end

endmodule

// File: rtl/bst_col_seq_chk.sv
module bst_col_seq_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             term,
    input logic [COL_W-1:0] col_addr,
    input logic             col_vld,
    input logic             col_last,
    input logic             mode_err,
    input logic             full_q,
    input logic [COL_W-1:0] mask_q
);

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (col_vld && col_addr == $past(start_col))); // R2

    AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && term && col_vld) |=> col_vld); // R10

    AST_TERM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !start) |=> !col_vld); // R8

    AST_LAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !start) |=> !col_vld); // R5

    AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> (col_vld && !full_q)); // R6

    AST_ERR_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> col_vld); // R9

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !col_vld |-> (col_addr == '0 && !col_last && !mode_err)); // R1

    AST_BLOCK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld && !col_last && !start && !term) |=>
            (col_vld && ((col_addr ^ $past(col_addr)) & ~$past(mask_q)) == '0)); // R3

    AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld && full_q && !start && !term) |=>
            (col_vld && col_addr == COL_W'($past(col_addr) + 1'b1))); // R7

endmodule

bind bst_col_seq bst_col_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_col (start_col),
    .term      (term),
    .col_addr  (col_addr),
    .col_vld   (col_vld),
    .col_last  (col_last),
    .mode_err  (mode_err),
    .full_q    (full_q),
    .mask_q    (mask_q)
);

// File: tb/sim_bst_col_seq.sv
module sim_bst_col_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [7:0] start_col;
    logic [2:0] bl_code;
    logic       wrap_il;
    logic       term;
    logic [7:0] col_addr;
    logic       col_vld;
    logic       col_last;
    logic       mode_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    bst_col_seq #(.COL_W(8)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_col (start_col),
        .bl_code   (bl_code),
        .wrap_il   (wrap_il),
        .term      (term),
        .col_addr  (col_addr),
        .col_vld   (col_vld),
        .col_last  (col_last),
        .mode_err  (mode_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ref_col(input int s, input int n, input int bl, input bit il);
        int m;
        m = bl - 1;
        if (il) return (s ^ (n & m)) & 255;
        return ((s & ~m) | ((s + n) & m)) & 255;
    endfunction

    // one beat check against the reference model
    task automatic chk_beat(input int s, input int n, input int bl, input bit il,
                            input bit last_exp, input bit err_exp);
        chk(col_vld === 1'b1, "R5 vld", int'(col_vld), 1);
        chk(int'(col_addr) == ref_col(s, n, bl, il), il ? "R4 col" : "R3 col",
            int'(col_addr), ref_col(s, n, bl, il));
        chk(col_last === last_exp, "R6 last", int'(col_last), int'(last_exp));
        chk(mode_err === err_exp, "R9 err", int'(mode_err), int'(err_exp));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start = 1'b0; start_col = '0; bl_code = '0; wrap_il = 1'b0; term = 1'b0;
        repeat (3) @(negedge clk);
        chk(col_vld === 1'b0 && col_last === 1'b0 && mode_err === 1'b0, "R1 in reset",
            int'({col_vld, col_last, mode_err}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(col_vld === 1'b0 && col_addr === 8'd0, "R1 after reset", int'(col_addr), 0);
    endtask

    // full fixed burst compared beat by beat, then idle check
    task automatic t_burst(input int s, input logic [2:0] code, input bit il);
        int  bl;
        bit  err;
        err = code[2] && il;
        bl  = code[2] ? 8 : (1 << code[1:0]);
        @(negedge clk);
        start = 1'b1; start_col = 8'(s); bl_code = code; wrap_il = il;
        for (int n = 0; n < bl; n++) begin
            @(negedge clk);
            start = 1'b0;
            if (n == 0) chk(int'(col_addr) == s, "R2 beat0", int'(col_addr), s);
            chk_beat(s, n, bl, il, n == bl - 1, err);
        end
        @(negedge clk);
        chk(col_vld === 1'b0 && col_addr === 8'd0, "R5 end of burst", int'(col_vld), 0);
    endtask

    task automatic t_sweep();
        for (int il = 0; il < 2; il++) begin
            for (int c = 0; c < 4; c++) begin
                for (int s = 0; s < 256; s++) begin
                    t_burst(s, 3'(c), il[0]);
                end
            end
        end
    endtask

    // full page from near the top of the row, wraps, then terminate
    task automatic t_full_page();
        @(negedge clk);
        start = 1'b1; start_col = 8'd250; bl_code = 3'b100; wrap_il = 1'b0;
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            start = 1'b0;
            chk_beat(250, n, 256, 1'b0, 1'b0, 1'b0);
            if (n == 12) chk(int'(col_addr) == 6, "R7 wrap", int'(col_addr), 6);
        end
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        chk(col_vld === 1'b0, "R8 term full page", int'(col_vld), 0);
    endtask

    task automatic t_term_fixed();
        @(negedge clk);
        start = 1'b1; start_col = 8'd17; bl_code = 3'd3; wrap_il = 1'b0;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            start = 1'b0;
            chk_beat(17, n, 8, 1'b0, 1'b0, 1'b0);
        end
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        chk(col_vld === 1'b0 && col_last === 1'b0, "R8 term fixed", int'(col_vld), 0);
    endtask

    task automatic t_illegal();
        t_burst(8'h5d, 3'b100, 1'b1);
        t_burst(8'h02, 3'b111, 1'b1);
        chk(mode_err === 1'b0, "R9 err clears", int'(mode_err), 0);
    endtask

    // restart mid-burst; start held with term to check priority
    task automatic t_restart();
        @(negedge clk);
        start = 1'b1; start_col = 8'd10; bl_code = 3'd3; wrap_il = 1'b0;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            start = 1'b0;
            chk_beat(10, n, 8, 1'b0, 1'b0, 1'b0);
        end
        start = 1'b1; start_col = 8'h43; bl_code = 3'd2; wrap_il = 1'b1; term = 1'b1;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            start = 1'b0; term = 1'b0;
            if (n == 0) chk(int'(col_addr) == 8'h43, "R10 restart col", int'(col_addr), 8'h43);
            chk_beat(8'h43, n, 4, 1'b1, n == 3, 1'b0);
        end
        @(negedge clk);
        chk(col_vld === 1'b0, "R10 new length", int'(col_vld), 0);
    endtask

    // mode inputs changed mid-burst are ignored
    task automatic t_mode_hold();
        @(negedge clk);
        start = 1'b1; start_col = 8'd5; bl_code = 3'd2; wrap_il = 1'b0;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            start = 1'b0;
            bl_code = 3'b100; wrap_il = 1'b1; start_col = 8'hff;
            chk_beat(5, n, 4, 1'b0, n == 3, 1'b0);
            chk(int'(col_addr) == ref_col(5, n, 4, 1'b0), "R11 mode held",
                int'(col_addr), ref_col(5, n, 4, 1'b0));
        end
        @(negedge clk);
        chk(col_vld === 1'b0 && mode_err === 1'b0, "R11 length held", int'(col_vld), 0);
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_full_page();
        t_term_fixed();
        t_illegal();
        t_restart();
        t_mode_hold();
        done = 1'b1;
        finish_up();
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            finish_up();
        end
    end

endmodule